// File: doc/BRIEF.md
# Deferred-Fault Poison Flag Register with Commit

This block keeps one poison bit per architectural register for a 64-entry register file. A poison bit marks a register whose value came from an operation that met a fault but was told not to trap. Instead of trapping, that operation set the bit and left the fault for later. The 64 bits are kept as two 32-bit halves. Indices 0 to 31 form the high half and indices 32 to 63 form the low half. Each half can be reported available or unavailable on its own.

Poison bits are raised in two ways:
- A single-index set request from a non-trapping operation.
- An OR-merge of a full 64-bit vector that was gathered over a group of parallel operations.

A commit operation does three things:
- It tests poison, either on one register or on whole halves.
- It always clears what it tested.
- When the control register is present, valid and enabled and the tested poison was set, it raises a one-cycle commit exception. Together with the exception it sends out a request to clear the matching status and address records. That request carries the commit index.

Top module: `poison_flag_reg`

## Requirements
- R1: While `rst` is high, all 64 flags are zero and `cmt_exc` and `rec_clr` are low. This state is seen on the first falling edge after reset is released.
- R2: A set request (`set_vld`=1) makes flag `set_idx` read 1 one cycle later. No other flag changes. Bit i of `flags` is the flag of register i.
- R3: A merge (`merge_vld`=1) ORs `merge_vec` into all 64 flags one cycle later.
- R4: A commit with a non-negative `cmt_idx` (7-bit two's complement, bit 6 = 0) tests flag `cmt_idx`. It clears only that flag, whether or not an exception is raised.
- R5: A commit with a negative `cmt_idx` tests this condition: (`hi_avail` and any of flags 0..31 set) or (`lo_avail` and any of flags 32..63 set). It zeroes every half whose availability bit is 1.
- R6: `cmt_exc` and `rec_clr` pulse high for one cycle, one cycle after a commit, when `ctl_impl`, `ctl_valid`, `ctl_en` and the tested condition are all 1. `rec_clr_idx` then equals the commit's `cmt_idx`. If any of those four is 0, neither pulse occurs.
- R7: A non-negative commit is ignored when its half is unavailable. Indices 0..31 need `hi_avail` and indices 32..63 need `lo_avail`. An ignored commit clears nothing and raises no exception.
- R8: When a set or a merge and a commit clear touch the same flag in the same cycle, the flag ends up 0.
- R9: Without a commit in the previous cycle, `cmt_exc` and `rec_clr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_vld | input | 1 | Single-flag set request |
| set_idx | input | 6 | Register index to poison |
| merge_vld | input | 1 | Accumulated-vector merge request |
| merge_vec | input | 64 | Flags to OR in |
| cmt_vld | input | 1 | Commit request |
| cmt_idx | input | 7 | Signed commit index; negative means whole halves |
| hi_avail | input | 1 | Flags 0..31 are accessible |
| lo_avail | input | 1 | Flags 32..63 are accessible |
| ctl_impl | input | 1 | Control register is implemented |
| ctl_valid | input | 1 | Control register valid bit |
| ctl_en | input | 1 | Commit exception enable bit |
| flags | output | 64 | Current poison flags |
| cmt_exc | output | 1 | Commit exception pulse |
| rec_clr | output | 1 | Request to clear status and address records |
| rec_clr_idx | output | 7 | Commit index for the record clear |

## Verification
The hardest situations to reach from the ports are two kinds of collision. In the first, a set or merge and a commit clear land on the same flag in the same cycle. In the second, a whole-half commit finds poison only in a half it may not touch, so nothing may fire and that half must survive. Directed steps build both cases: poison is planted in one half, then commits run with the other half's availability alone. The random phase draws set and commit indices from a narrow window and often makes them equal. This makes collisions, negative indices and partly disabled control bits frequent.

// File: rtl/poison_pkg.sv
package poison_pkg;
  typedef enum logic [1:0] {
    CK_NONE   = 2'd0,
    CK_SINGLE = 2'd1,
    CK_WHOLE  = 2'd2
  } cmt_kind_e;
endpackage

// File: rtl/poison_decode.sv
module poison_decode #(
  parameter int FLAGS = 64,
  parameter int POS_W = 6
) (
  input  logic [POS_W-1:0] pos,
  output logic [FLAGS-1:0] onehot
);
  for (genvar i = 0; i < FLAGS; i++) begin : g_bit
    assign onehot[i] = (pos == POS_W'(i));
  end
endmodule

// File: rtl/poison_set_merge.sv
module poison_set_merge #(
  parameter int FLAGS = 64,
  parameter int POS_W = 6
) (
  input  logic             set_vld,
  input  logic [POS_W-1:0] set_idx,
  input  logic             merge_vld,
  input  logic [FLAGS-1:0] merge_vec,
  output logic [FLAGS-1:0] set_mask
);
  logic [FLAGS-1:0] set_hot;

  poison_decode #(.FLAGS(FLAGS), .POS_W(POS_W)) u_dec (
    .pos    (set_idx),
    .onehot (set_hot)
  );

  always_comb begin
    set_mask = '0;
    if (set_vld)   set_mask = set_mask | set_hot;
    if (merge_vld) set_mask = set_mask | merge_vec;
  end
endmodule

// File: rtl/poison_commit.sv
module poison_commit
  import poison_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int FLAGS  = 64,
  parameter int POS_W  = 6,
  parameter int IDX_W  = 7
) (
  input  logic [FLAGS-1:0] flags_cur,
  input  logic             cmt_vld,
  input  logic [IDX_W-1:0] cmt_idx,
  input  logic             hi_avail,
  input  logic             lo_avail,
  output logic             tested,
  output logic [FLAGS-1:0] clr_mask
);
  localparam int NHALF = 2;

  logic [NHALF-1:0] avail;
  logic [NHALF-1:0] half_any;
  logic [FLAGS-1:0] whole_mask;
  logic [FLAGS-1:0] one_hot;
  logic [POS_W-1:0] pos;
  logic             neg;
  logic             half_sel;
  logic             reach;
  cmt_kind_e        kind;

  assign avail    = {lo_avail, hi_avail};
  assign neg      = cmt_idx[IDX_W-1];
  assign pos      = cmt_idx[POS_W-1:0];
  assign half_sel = pos[POS_W-1];

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    assign half_any[h] = |flags_cur[h*HALF_W +: HALF_W];
    assign whole_mask[h*HALF_W +: HALF_W] = {HALF_W{avail[h]}};
  end

  poison_decode #(.FLAGS(FLAGS), .POS_W(POS_W)) u_dec (
    .pos    (pos),
    .onehot (one_hot)
  );

  assign reach = neg ? (|avail) : avail[half_sel];

  always_comb begin
    if (!cmt_vld || !reach) kind = CK_NONE;
    else if (neg)           kind = CK_WHOLE;
    else                    kind = CK_SINGLE;
  end

  always_comb begin
    tested   = 1'b0;
    clr_mask = '0;
    case (kind)
      CK_SINGLE: begin
        tested   = flags_cur[pos];
        clr_mask = one_hot;
      end
      CK_WHOLE: begin
        tested   = |(half_any & avail);
        clr_mask = whole_mask;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/poison_flag_reg.sv
module poison_flag_reg #(
  parameter int HALF_W = 32,
  localparam int FLAGS = 2 * HALF_W,
  localparam int POS_W = $clog2(FLAGS),
  localparam int IDX_W = POS_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_vld,
  input  logic [POS_W-1:0] set_idx,
  input  logic             merge_vld,
  input  logic [FLAGS-1:0] merge_vec,
  input  logic             cmt_vld,
  input  logic [IDX_W-1:0] cmt_idx,
  input  logic             hi_avail,
  input  logic             lo_avail,
  input  logic             ctl_impl,
  input  logic             ctl_valid,
  input  logic             ctl_en,
  output logic [FLAGS-1:0] flags,
  output logic             cmt_exc,
  output logic             rec_clr,
  output logic [IDX_W-1:0] rec_clr_idx
);
  logic [FLAGS-1:0] flags_q;
  logic [FLAGS-1:0] set_mask;
  logic [FLAGS-1:0] clr_mask;
  logic             tested;
  logic             fire;

  poison_set_merge #(.FLAGS(FLAGS), .POS_W(POS_W)) u_set (
    .set_vld   (set_vld),
    .set_idx   (set_idx),
    .merge_vld (merge_vld),
    .merge_vec (merge_vec),
    .set_mask  (set_mask)
  );

  poison_commit #(.HALF_W(HALF_W), .FLAGS(FLAGS), .POS_W(POS_W), .IDX_W(IDX_W)) u_cmt (
    .flags_cur (flags_q),
    .cmt_vld   (cmt_vld),
    .cmt_idx   (cmt_idx),
    .hi_avail  (hi_avail),
    .lo_avail  (lo_avail),
    .tested    (tested),
    .clr_mask  (clr_mask)
  );

  assign fire = tested & ctl_impl & ctl_valid & ctl_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q     <= '0;
      cmt_exc     <= 1'b0;
      rec_clr     <= 1'b0;
      rec_clr_idx <= '0;
    end else begin
      flags_q     <= (flags_q | set_mask) & ~clr_mask;
      cmt_exc     <= fire;
      rec_clr     <= fire;
      rec_clr_idx <= fire ? cmt_idx : '0;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/poison_flag_chk.sv
module poison_flag_chk #(
  parameter int HALF_W = 32,
  localparam int FLAGS = 2 * HALF_W,
  localparam int POS_W = $clog2(FLAGS),
  localparam int IDX_W = POS_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             set_vld,
  input logic [POS_W-1:0] set_idx,
  input logic             merge_vld,
  input logic [FLAGS-1:0] merge_vec,
  input logic             cmt_vld,
  input logic [IDX_W-1:0] cmt_idx,
  input logic             hi_avail,
  input logic             lo_avail,
  input logic [FLAGS-1:0] flags,
  input logic             cmt_exc,
  input logic             rec_clr,
  input logic [IDX_W-1:0] rec_clr_idx
);
  logic             rst_q;
  logic             p_set, p_merge, p_cmt, p_hi, p_lo;
  logic [POS_W-1:0] p_set_idx;
  logic [FLAGS-1:0] p_merge_vec, p_flags;
  logic [IDX_W-1:0] p_cmt_idx;
  logic             p_neg, p_reach;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      p_set <= 1'b0; p_merge <= 1'b0; p_cmt <= 1'b0;
      p_hi <= 1'b0; p_lo <= 1'b0;
      p_set_idx <= '0; p_merge_vec <= '0; p_flags <= '0; p_cmt_idx <= '0;
    end else begin
      p_set <= set_vld; p_merge <= merge_vld; p_cmt <= cmt_vld;
      p_hi <= hi_avail; p_lo <= lo_avail;
      p_set_idx <= set_idx; p_merge_vec <= merge_vec;
      p_flags <= flags; p_cmt_idx <= cmt_idx;
    end
  end

  assign p_neg   = p_cmt_idx[IDX_W-1];
  assign p_reach = p_cmt_idx[POS_W-1] ? p_lo : p_hi;

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst_q |-> (flags == '0 && !cmt_exc && !rec_clr));

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (p_set && !p_cmt) |-> flags[p_set_idx]);

  // R3
  merge_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (p_merge && !p_cmt) |-> ((flags & p_merge_vec) == p_merge_vec));

  // R4
  single_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (p_cmt && !p_neg && p_reach) |-> !flags[p_cmt_idx[POS_W-1:0]]);

  // R5
  whole_hi_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (p_cmt && p_neg && p_hi) |-> (flags[HALF_W-1:0] == '0));

  // R5
  whole_lo_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (p_cmt && p_neg && p_lo) |-> (flags[FLAGS-1:HALF_W] == '0));

  // R6
  record_idx_chk: assert property (@(posedge clk) disable iff (rst)
    rec_clr |-> (cmt_exc && rec_clr_idx == p_cmt_idx));

  // R7
  unreachable_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (p_cmt && !p_neg && !p_reach && !p_set && !p_merge) |->
      (flags == p_flags && !cmt_exc));

  // R9
  no_commit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !p_cmt |-> (!cmt_exc && !rec_clr));
endmodule

bind poison_flag_reg poison_flag_chk #(.HALF_W(HALF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .set_vld     (set_vld),
  .set_idx     (set_idx),
  .merge_vld   (merge_vld),
  .merge_vec   (merge_vec),
  .cmt_vld     (cmt_vld),
  .cmt_idx     (cmt_idx),
  .hi_avail    (hi_avail),
  .lo_avail    (lo_avail),
  .flags       (flags),
  .cmt_exc     (cmt_exc),
  .rec_clr     (rec_clr),
  .rec_clr_idx (rec_clr_idx)
);

// File: tb/poison_flag_reg_bench.sv
module poison_flag_reg_bench;
  localparam int HW = 32;
  localparam int FW = 64;

  logic          clk = 1'b0;
  logic          rst;
  logic          set_vld;
  logic [5:0]    set_idx;
  logic          merge_vld;
  logic [FW-1:0] merge_vec;
  logic          cmt_vld;
  logic [6:0]    cmt_idx;
  logic          hi_avail, lo_avail;
  logic          ctl_impl, ctl_valid, ctl_en;
  logic [FW-1:0] flags;
  logic          cmt_exc, rec_clr;
  logic [6:0]    rec_clr_idx;

  int checks = 0;
  int fails  = 0;
  logic [FW-1:0] m_flags;

  always #10 clk = ~clk;

  poison_flag_reg #(.HALF_W(HW)) u_poison_flag_reg (
    .clk(clk), .rst(rst),
    .set_vld(set_vld), .set_idx(set_idx),
    .merge_vld(merge_vld), .merge_vec(merge_vec),
    .cmt_vld(cmt_vld), .cmt_idx(cmt_idx),
    .hi_avail(hi_avail), .lo_avail(lo_avail),
    .ctl_impl(ctl_impl), .ctl_valid(ctl_valid), .ctl_en(ctl_en),
    .flags(flags), .cmt_exc(cmt_exc), .rec_clr(rec_clr), .rec_clr_idx(rec_clr_idx)
  );

  task automatic chk(input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected tested condition computed from the requirements (R4, R5, R7).
  function automatic logic model_tested(input logic [FW-1:0] f);
    logic [5:0] p;
    if (!cmt_vld) return 1'b0;
    if (cmt_idx[6])
      return (hi_avail && (|f[HW-1:0])) || (lo_avail && (|f[FW-1:HW]));
    p = cmt_idx[5:0];
    if (p < 6'(HW) ? !hi_avail : !lo_avail) return 1'b0;
    return f[p];
  endfunction

  function automatic logic [FW-1:0] model_clear();
    logic [FW-1:0] m;
    logic [5:0] p;
    m = '0;
    if (!cmt_vld) return m;
    if (cmt_idx[6]) begin
      if (hi_avail) m[HW-1:0]  = '1;
      if (lo_avail) m[FW-1:HW] = '1;
      return m;
    end
    p = cmt_idx[5:0];
    if (p < 6'(HW) ? hi_avail : lo_avail) m[p] = 1'b1;
    return m;
  endfunction

  task automatic idle();
    set_vld = 0; set_idx = '0; merge_vld = 0; merge_vec = '0;
    cmt_vld = 0; cmt_idx = '0; hi_avail = 1; lo_avail = 1;
    ctl_impl = 1; ctl_valid = 1; ctl_en = 1;
  endtask

  // Inputs are already driven at a falling edge; advance one cycle and compare.
  task automatic step(input string tag);
    logic [FW-1:0] nxt;
    logic          exc;
    logic [6:0]    ci;
    exc = model_tested(m_flags) && ctl_impl && ctl_valid && ctl_en;
    ci  = cmt_idx;
    nxt = m_flags;
    if (set_vld)   nxt[set_idx] = 1'b1;
    if (merge_vld) nxt = nxt | merge_vec;
    nxt = nxt & ~model_clear();
    @(posedge clk);
    @(negedge clk);
    m_flags = nxt;
    chk({tag, " flags"}, flags, m_flags);
    chk({tag, " cmt_exc"}, FW'(cmt_exc), FW'(exc));
    chk({tag, " rec_clr"}, FW'(rec_clr), FW'(exc));
    if (exc) chk({tag, " rec_clr_idx"}, FW'(rec_clr_idx), FW'(ci));
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    idle();
    rst = 1;
    m_flags = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reset flags", flags, '0);
    chk("R1 reset exc", FW'({cmt_exc, rec_clr}), '0);

    set_vld = 1; set_idx = 6'd5;  step("R2 set 5");
    set_vld = 1; set_idx = 6'd40; step("R2 set 40");
    merge_vld = 1; merge_vec = 64'h8000_0001_0000_0300; step("R3 merge");
    cmt_vld = 1; cmt_idx = 7'd5; step("R4 R6 commit 5 fires");
    cmt_vld = 1; cmt_idx = 7'd40; ctl_en = 0; step("R4 R6 commit 40 disabled");
    cmt_vld = 1; cmt_idx = 7'd9; hi_avail = 0; step("R7 commit 9 hi unavailable");
    cmt_vld = 1; cmt_idx = 7'd63; lo_avail = 0; step("R7 commit 63 lo unavailable");
    cmt_vld = 1; cmt_idx = 7'd6; step("R9 R4 commit clear flag no fire");
    step("R9 idle");
    cmt_vld = 1; cmt_idx = 7'h7F; lo_avail = 0; step("R5 R6 neg hi only");
    cmt_vld = 1; cmt_idx = 7'h40; ctl_impl = 0; step("R5 R6 neg unimplemented");
    merge_vld = 1; merge_vec = 64'h0000_0010_0000_0000; step("R3 plant lo");
    cmt_vld = 1; cmt_idx = 7'h7F; lo_avail = 0; step("R5 neg hi only lo poisoned");
    cmt_vld = 1; cmt_idx = 7'h7E; hi_avail = 0; lo_avail = 0; step("R7 neg none available");
    set_vld = 1; set_idx = 6'd12; cmt_vld = 1; cmt_idx = 7'd12; step("R8 set vs clear");
    merge_vld = 1; merge_vec = '1; cmt_vld = 1; cmt_idx = 7'h7F; step("R8 merge vs whole clear");

    for (int n = 0; n < 3000; n++) begin
      set_vld   = ($urandom % 2) == 0;
      set_idx   = 6'($urandom % 8) + (($urandom % 2) != 0 ? 6'd30 : 6'd0);
      merge_vld = ($urandom % 8) == 0;
      merge_vec = {$urandom, $urandom} & {$urandom, $urandom};
      cmt_vld   = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: cmt_idx = {1'b0, set_idx};
        1: cmt_idx = 7'h40 | 7'($urandom % 64);
        default: cmt_idx = {1'b0, 6'($urandom % 8) + (($urandom % 2) != 0 ? 6'd30 : 6'd0)};
      endcase
      hi_avail  = ($urandom % 4) != 0;
      lo_avail  = ($urandom % 4) != 0;
      ctl_impl  = ($urandom % 8) != 0;
      ctl_valid = ($urandom % 8) != 0;
      ctl_en    = ($urandom % 8) != 0;
      step("R2 R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule